// File: doc/BRIEF.md
# Huge-Page Region Walk-Frequency Tracker

This block sits beside a hardware page walker and keeps a small, fixed-size, fully associative record of which huge-page-sized virtual regions cause the most page-table walks. Every walk that the walker starts after a last-level TLB miss is presented on a valid/ready strobe together with the virtual page number that missed. The tracker removes the low page-number bits to form a region tag. It then either bumps the count of the matching entry, fills a free slot, or evicts the entry with the lowest count. TLB hits never reach it.

System software reads the table back by rank. It asks for the entry at rank k in descending count order and receives that region's tag and walk count one cycle later. It uses that list to choose which regions to back with huge pages. A single clear command empties the table so that a new observation window can start.

Top module: `hp_region_tracker`

## Requirements
- R1: After reset the table is empty: a readout of any rank returns `rd_valid` = 0, and `walk_ready` is 1 while `clear` is low.
- R2: The region tag of a walk is `walk_vpn` shifted right by log2(REGION_PAGES), which is 9 bits by default. Two page numbers that differ only in those 9 low bits update the same entry.
- R3: An accepted walk whose tag matches an occupied entry increases that entry's count by exactly 1.
- R4: An accepted walk that matches no entry while fewer than ENTRIES slots are occupied takes the lowest free slot with count 1. Slots fill in order 0, 1, 2, … after reset or clear.
- R5: An accepted walk that matches no entry while all slots are occupied replaces the entry with the smallest count, choosing the lowest slot index among equal counts. The new region keeps that slot and starts at count 1.
- R6: Counts are CNT_W (default 16) bits wide and stay at 65535 on further hits instead of wrapping.
- R7: While `clear` is high, `walk_ready` is 0 and a walk offered in that cycle is dropped. After that edge every slot is free.
- R8: `rd_done` is high exactly in the cycle after a cycle with `rd_req` high. The returned tag and count reflect the table as it stood before the edge that captured the request, so a walk accepted at that same edge is not yet included.
- R9: Rank 0 is the highest count. Entries with equal counts are ranked by ascending slot index.
- R10: `rd_valid` is 0 when `rd_rank` is greater than or equal to the number of occupied slots, and 1 otherwise.
- R11: At most one walk is taken per cycle, and only when `walk_valid` and `walk_ready` are both high. With `walk_valid` low the table does not change, whatever `walk_vpn` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid | input | 1 | A page-table walk is offered |
| walk_ready | output | 1 | Walk can be accepted this cycle (low during clear) |
| walk_vpn | input | VPN_W (36) | Virtual page number that caused the walk |
| clear | input | 1 | Empty the table |
| rd_req | input | 1 | Readout request |
| rd_rank | input | $clog2(ENTRIES) (5) | Rank requested, 0 = most walked |
| rd_done | output | 1 | Readout result is present |
| rd_valid | output | 1 | Requested rank is occupied |
| rd_tag | output | VPN_W-log2(REGION_PAGES) (27) | Region tag at that rank |
| rd_count | output | CNT_W (16) | Walk count at that rank |

## Verification
Two pairs of functions can collide in one cycle. The first is a walk offered alongside a clear. The bench raises `walk_valid` and `clear` together, checks that `walk_ready` is low, and then confirms by readout that nothing remains. The second is a readout request captured at the same edge as a hit on the entry it reports. The bench requires the pre-update count in that result and the incremented count in the following readout.

// File: rtl/hp_region_tracker.sv
module hp_region_tracker #(
  parameter int ENTRIES      = 32,
  parameter int VPN_W        = 36,
  parameter int REGION_PAGES = 512,
  parameter int CNT_W        = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   walk_valid,
  output logic                                   walk_ready,
  input  logic [VPN_W-1:0]                       walk_vpn,
  input  logic                                   clear,
  input  logic                                   rd_req,
  input  logic [$clog2(ENTRIES)-1:0]             rd_rank,
  output logic                                   rd_done,
  output logic                                   rd_valid,
  output logic [VPN_W-$clog2(REGION_PAGES)-1:0]  rd_tag,
  output logic [CNT_W-1:0]                       rd_count
);
  localparam int SHIFT = $clog2(REGION_PAGES);
  localparam int TAG_W = VPN_W - SHIFT;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int OCC_W = $clog2(ENTRIES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [OCC_W-1:0] occ_q;

  logic [TAG_W-1:0] walk_tag;
  logic             acc, full, hit;
  logic [IDX_W-1:0] hit_idx, vic_idx, sel_idx;
  logic             sel_hit;
  logic [OCC_W-1:0] rk;

  wire unused_low = &{1'b0, walk_vpn[SHIFT-1:0]};

  assign walk_tag   = walk_vpn[VPN_W-1:SHIFT];
  assign walk_ready = ~clear;
  assign acc        = walk_valid & walk_ready;
  assign full       = (occ_q == OCC_W'(ENTRIES));

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && OCC_W'(i) < occ_q && tag_q[i] == walk_tag) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    vic_idx = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (cnt_q[i] < cnt_q[vic_idx]) vic_idx = IDX_W'(i);
    end
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    rk      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      rk = '0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (OCC_W'(j) < occ_q &&
            (cnt_q[j] > cnt_q[i] || (cnt_q[j] == cnt_q[i] && j < i)))
          rk = rk + OCC_W'(1);
      end
      if (OCC_W'(i) < occ_q && rk == OCC_W'(rd_rank)) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (clear) begin
      occ_q <= '0;
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= '0;
    end else if (acc) begin
      if (hit) begin
        if (cnt_q[hit_idx] != CNT_MAX) cnt_q[hit_idx] <= cnt_q[hit_idx] + CNT_W'(1);
      end else if (!full) begin
        tag_q[IDX_W'(occ_q)] <= walk_tag;
        cnt_q[IDX_W'(occ_q)] <= CNT_W'(1);
        occ_q                <= occ_q + OCC_W'(1);
      end else begin
        tag_q[vic_idx] <= walk_tag;
        cnt_q[vic_idx] <= CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_done  <= 1'b0;
      rd_valid <= 1'b0;
      rd_tag   <= '0;
      rd_count <= '0;
    end else begin
      rd_done  <= rd_req;
      rd_valid <= rd_req & sel_hit;
      if (rd_req) begin
        rd_tag   <= sel_hit ? tag_q[sel_idx] : '0;
        rd_count <= sel_hit ? cnt_q[sel_idx] : '0;
      end
    end
  end

  p_alloc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit && !full) |=> occ_q == $past(occ_q) + OCC_W'(1));

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> occ_q == '0);

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!walk_valid && !clear) |=> $stable(occ_q));

  p_done_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_done);

  p_valid_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_done);

  p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(ENTRIES));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_sat_chk
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == CNT_MAX && !clear && !(acc && !hit && full && vic_idx == IDX_W'(g)))
      |=> cnt_q[g] == CNT_MAX);
  end
endmodule

// File: tb/tb_hp_region_tracker.sv
`timescale 1ns/1ps
module tb_hp_region_tracker;
  localparam int ENTRIES = 32;
  localparam int VPN_W   = 36;
  localparam int SHIFT   = 9;
  localparam int TAG_W   = VPN_W - SHIFT;
  localparam int CMAX    = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic walk_valid = 1'b0;
  logic walk_ready;
  logic [VPN_W-1:0] walk_vpn = '0;
  logic clear = 1'b0;
  logic rd_req = 1'b0;
  logic [4:0] rd_rank = '0;
  logic rd_done, rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [15:0] rd_count;

  int total = 0;
  int bad = 0;

  logic [TAG_W-1:0] m_tag [ENTRIES];
  int               m_cnt [ENTRIES];
  int               m_occ = 0;

  always #4 clk = ~clk;

  hp_region_tracker dut (
    .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .walk_ready(walk_ready),
    .walk_vpn(walk_vpn), .clear(clear), .rd_req(rd_req), .rd_rank(rd_rank),
    .rd_done(rd_done), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_count(rd_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic void model_walk(input logic [VPN_W-1:0] vpn);
    logic [TAG_W-1:0] t;
    int found;
    int v;
    t = vpn[VPN_W-1:SHIFT];
    found = -1;
    for (int i = 0; i < m_occ; i++) if (found < 0 && m_tag[i] == t) found = i;
    if (found >= 0) begin
      if (m_cnt[found] < CMAX) m_cnt[found]++;
    end else if (m_occ < ENTRIES) begin
      m_tag[m_occ] = t;
      m_cnt[m_occ] = 1;
      m_occ++;
    end else begin
      v = 0;
      for (int i = 0; i < ENTRIES; i++) if (m_cnt[i] < m_cnt[v]) v = i;
      m_tag[v] = t;
      m_cnt[v] = 1;
    end
  endfunction

  task automatic walk(input logic [VPN_W-1:0] vpn);
    walk_valid = 1'b1;
    walk_vpn   = vpn;
    tick();
    walk_valid = 1'b0;
    model_walk(vpn);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    tick();
    clear = 1'b0;
    m_occ = 0;
  endtask

  task automatic read(input int rank);
    rd_req  = 1'b1;
    rd_rank = 5'(rank);
    tick();
    rd_req = 1'b0;
  endtask

  task automatic check_all(input string req);
    int ord [ENTRIES];
    int tmp;
    for (int k = 0; k < m_occ; k++) ord[k] = k;
    for (int a = 0; a < m_occ; a++)
      for (int b = 0; b + 1 < m_occ - a; b++)
        if (m_cnt[ord[b]] < m_cnt[ord[b+1]]) begin
          tmp = ord[b]; ord[b] = ord[b+1]; ord[b+1] = tmp;
        end
    for (int r = 0; r < ENTRIES; r++) begin
      read(r);
      chk({req, " done"}, 64'(rd_done), 64'(1));
      chk({req, " R10 valid"}, 64'(rd_valid), 64'(r < m_occ));
      if (r < m_occ) begin
        chk({req, " tag"}, 64'(rd_tag), 64'(m_tag[ord[r]]));
        chk({req, " count"}, 64'(rd_count), 64'(m_cnt[ord[r]]));
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", 64'(walk_ready), 64'(1));
    chk("R8 no done without request", 64'(rd_done), 64'(0));
    read(0);
    chk("R1 rank0 empty", 64'(rd_valid), 64'(0));
    chk("R8 done", 64'(rd_done), 64'(1));
    tick();
    chk("R8 done one cycle only", 64'(rd_done), 64'(0));
  endtask

  task automatic t_region();
    do_clear();
    walk(36'h1200);
    walk(36'h13FF);
    walk(36'h1400);
    read(0);
    chk("R2 shared region tag", 64'(rd_tag), 64'(9));
    chk("R3 shared region count", 64'(rd_count), 64'(2));
    read(1);
    chk("R4 next region tag", 64'(rd_tag), 64'(10));
    chk("R4 new entry count", 64'(rd_count), 64'(1));
    read(2);
    chk("R10 rank past occupancy", 64'(rd_valid), 64'(0));
    read(31);
    chk("R10 top rank empty", 64'(rd_valid), 64'(0));
    check_all("R2");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 5; k++) begin
      walk_vpn = 36'(k * 36'h12345 + 36'h777000);
      chk("R11 ready idle", 64'(walk_ready), 64'(1));
      tick();
    end
    check_all("R11");
  endtask

  task automatic t_replace();
    do_clear();
    for (int i = 0; i < ENTRIES; i++)
      for (int c = 0; c <= i % 3; c++) walk(36'((100 + i) << SHIFT) | 36'(c));
    check_all("R9");
    walk(36'(500) << SHIFT);
    read(21);
    chk("R5 victim slot new tag", 64'(rd_tag), 64'(500));
    chk("R5 victim slot count", 64'(rd_count), 64'(1));
    check_all("R5");
    walk(36'(501) << SHIFT);
    check_all("R5 second");
    walk(36'(103) << SHIFT);
    check_all("R3 after replace");
  endtask

  task automatic t_clear();
    walk_valid = 1'b1;
    walk_vpn   = 36'(900) << SHIFT;
    clear      = 1'b1;
    #1;
    chk("R7 ready low during clear", 64'(walk_ready), 64'(0));
    tick();
    clear      = 1'b0;
    walk_valid = 1'b0;
    m_occ      = 0;
    read(0);
    chk("R7 empty after clear", 64'(rd_valid), 64'(0));
    chk("R7 ready back", 64'(walk_ready), 64'(1));
    walk(36'(901) << SHIFT);
    check_all("R7");
  endtask

  task automatic t_snapshot();
    do_clear();
    walk(36'(42) << SHIFT);
    walk_valid = 1'b1;
    walk_vpn   = 36'(42) << SHIFT;
    read(0);
    walk_valid = 1'b0;
    model_walk(36'(42) << SHIFT);
    chk("R8 pre-update count", 64'(rd_count), 64'(1));
    read(0);
    chk("R8 post-update count", 64'(rd_count), 64'(2));
  endtask

  task automatic t_sat();
    do_clear();
    walk_valid = 1'b1;
    walk_vpn   = 36'(77) << SHIFT;
    for (int k = 0; k < CMAX + 5; k++) begin
      tick();
      model_walk(36'(77) << SHIFT);
    end
    walk_valid = 1'b0;
    read(0);
    chk("R6 saturated count", 64'(rd_count), 64'(CMAX));
    chk("R6 saturated tag", 64'(rd_tag), 64'(77));
    walk(36'(78) << SHIFT);
    check_all("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_region();
    t_idle();
    t_replace();
    t_clear();
    t_snapshot();
    t_sat();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule